// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Router with Broadcast

This block moves one packet per input line to the output lines of an N-port network in a single pass. It is built as log2 N stages of 2x2 switch elements. A perfect-shuffle wiring pattern sits in front of every stage. Each input line carries three things: a valid flag, a destination port number and a payload. It may also carry a broadcast flag and a wildcard mask. With these, one packet is copied to every port of an aligned group of outputs.

Every switch sets itself from one destination bit of the packets that reach it. The stage next to the inputs uses the most significant bit, and the last stage uses the least significant bit. A switch may be asked to drive the same output from both of its inputs. In that case the packet on its upper input keeps the output, and the other packet is dropped at that switch. The source of the dropped packet is then reported as blocked, so that the sender can present it again in a later pass.

Routing is purely combinational. The delivered packets, their source numbers and the blocked flags are registered at the output.

Top module: `omega_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_valid, out_src, out_data and out_blocked are all zero.
- R2: The result for the inputs sampled at a rising clock edge appears on the outputs right after that edge. The outputs do not change before it.
- R3: A unicast packet from input i with destination d that is not blocked appears on output port d. out_src carries i there, and out_data carries the payload of input i. Destination bit LOG-1 steers the first stage, and bit 0 steers the last stage.
- R4: When every input is valid and its destination is (i + c) mod N, for any constant c, all packets are delivered and no input is blocked.
- R5: When two requests need the same output of one switch, the request on the switch's upper input wins. The other request is not delivered, and out_blocked is set at the index of its source. Example with N=8: inputs 0 and 4 both going to port 0 give out_valid = 8'h01 and out_blocked = 8'h10.
- R6: An input whose valid flag is low produces no output and is never flagged blocked. With no valid input, every output is zero.
- R7: For an input with in_bcast high, each set bit j of its mask field makes destination bit j a wildcard. A mask of k low-order ones, with no other input valid, delivers the packet to every port p with p >> k equal to d >> k.
- R8: When in_bcast is low, the mask field of that input has no effect, and the packet is routed as a unicast.
- R9: A broadcast copy can lose at a later stage after its packet has already split. The surviving copies are still delivered, and the source is flagged blocked. Example with N=8: input 2 broadcasts with mask 3'b111 and input 0 sends a unicast to port 0. The result is out_valid = 8'hF1, with ports 4 to 7 sourced from input 2, and out_blocked = 8'h04.
- R10: A single valid input, unicast or broadcast, is never blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | Per-input request flag |
| in_bcast | input | N | Per-input broadcast enable |
| in_dst | input | N*LOG | Destination port, LOG bits per input |
| in_mask | input | N*LOG | Wildcard bits of the destination, used only with broadcast |
| in_data | input | N*DW | Payload, DW bits per input |
| out_valid | output | N | A packet is present on the output port |
| out_src | output | N*LOG | Input number of the packet on each port |
| out_data | output | N*DW | Payload on each port, zero when idle |
| out_blocked | output | N | Input lost at least one copy in this pass |

## Verification
Several properties are checked by assertions on every cycle. Each delivered packet must sit on a port that its registered destination and mask allow. Each unblocked source must reach exactly 2^popcount(mask) ports, and each blocked source must reach fewer. A lone request must never be blocked, and an idle input pattern must leave the outputs quiet. Which input actually wins a contested switch, the latency of exactly one edge, and the routing under shift patterns and random permutations can only be shown by the bench scenarios. Those scenarios compare every port and every blocked flag against a stage-by-stage reference and against closed-form group formulas.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Setting of one 2x2 element for the current pass
  typedef enum logic [2:0] {
    SW_IDLE     = 3'd0,
    SW_STRAIGHT = 3'd1,
    SW_EXCHANGE = 3'd2,
    SW_UBCAST   = 3'd3,
    SW_LBCAST   = 3'd4
  } sw_state_e;

  // Packed packet: {valid, src, dst, mask, data}
  function automatic int pkt_width(input int lg, input int dw);
    return 1 + 3 * lg + dw;
  endfunction

  // Perfect shuffle: line index rotated left by one bit
  function automatic int shuffle_pos(input int idx, input int lg);
    int all_ones;
    all_ones = (1 << lg) - 1;
    return ((idx << 1) | (idx >> (lg - 1))) & all_ones;
  endfunction

  // Output ports a packet asks for: bit 0 upper, bit 1 lower
  function automatic logic [1:0] port_request(input logic vld, input logic dbit,
                                              input logic wild);
    if (!vld) return 2'b00;
    if (wild) return 2'b11;
    return dbit ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
  import omega_pkg::*;
#(
  parameter int LOG   = 3,
  parameter int DW    = 8,
  parameter int STAGE = 0,
  localparam int PW   = pkt_width(LOG, DW)
) (
  input  logic [PW-1:0]  up_i,
  input  logic [PW-1:0]  lo_i,
  output logic [PW-1:0]  up_o,
  output logic [PW-1:0]  lo_o,
  output logic           blk_o,
  output logic [LOG-1:0] blk_src_o
);

  localparam int MSK_LO = DW;
  localparam int DST_LO = DW + LOG;
  localparam int SRC_LO = DW + 2 * LOG;
  localparam int VLD    = PW - 1;
  localparam int BIT    = LOG - 1 - STAGE;

  logic [1:0]  req_up, req_lo, grant_lo;
  logic        clash;
  logic [PW-1:0] lo_pass;
  sw_state_e   state;

  assign req_up   = port_request(up_i[VLD], up_i[DST_LO + BIT], up_i[MSK_LO + BIT]);
  assign req_lo   = port_request(lo_i[VLD], lo_i[DST_LO + BIT], lo_i[MSK_LO + BIT]);
  assign clash    = |(req_up & req_lo);
  assign grant_lo = clash ? 2'b00 : req_lo;
  assign lo_pass  = (grant_lo != 2'b00) ? lo_i : '0;

  always_comb begin
    if (req_up == 2'b11)                              state = SW_UBCAST;
    else if (grant_lo == 2'b11)                       state = SW_LBCAST;
    else if (req_up == 2'b01 || grant_lo == 2'b10)    state = SW_STRAIGHT;
    else if (req_up == 2'b10 || grant_lo == 2'b01)    state = SW_EXCHANGE;
    else                                              state = SW_IDLE;
  end

  always_comb begin
    case (state)
      SW_STRAIGHT: begin up_o = up_i;    lo_o = lo_pass; end
      SW_EXCHANGE: begin up_o = lo_pass; lo_o = up_i;    end
      SW_UBCAST:   begin up_o = up_i;    lo_o = up_i;    end
      SW_LBCAST:   begin up_o = lo_pass; lo_o = lo_pass; end
      default:     begin up_o = '0;      lo_o = '0;      end
    endcase
  end

  assign blk_o     = clash;
  assign blk_src_o = lo_i[SRC_LO +: LOG];

endmodule

// File: rtl/omega_stage.sv
module omega_stage
  import omega_pkg::*;
#(
  parameter int N     = 8,
  parameter int LOG   = 3,
  parameter int DW    = 8,
  parameter int STAGE = 0,
  localparam int PW   = pkt_width(LOG, DW)
) (
  input  logic [N*PW-1:0]      lines_i,
  output logic [N*PW-1:0]      lines_o,
  output logic [N/2-1:0]       blk_o,
  output logic [N/2*LOG-1:0]   blk_src_o
);

  logic [N*PW-1:0] shuf;

  for (genvar j = 0; j < N; j++) begin : g_shuffle
    assign shuf[shuffle_pos(j, LOG)*PW +: PW] = lines_i[j*PW +: PW];
  end

  for (genvar k = 0; k < N/2; k++) begin : g_sw
    omega_switch #(.LOG(LOG), .DW(DW), .STAGE(STAGE)) u_sw (
      .up_i      (shuf[(2*k)*PW +: PW]),
      .lo_i      (shuf[(2*k+1)*PW +: PW]),
      .up_o      (lines_o[(2*k)*PW +: PW]),
      .lo_o      (lines_o[(2*k+1)*PW +: PW]),
      .blk_o     (blk_o[k]),
      .blk_src_o (blk_src_o[k*LOG +: LOG])
    );
  end

endmodule

// File: rtl/omega_router.sv
module omega_router
  import omega_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          in_valid,
  input  logic [N-1:0]          in_bcast,
  input  logic [N*$clog2(N)-1:0] in_dst,
  input  logic [N*$clog2(N)-1:0] in_mask,
  input  logic [N*DW-1:0]       in_data,
  output logic [N-1:0]          out_valid,
  output logic [N*$clog2(N)-1:0] out_src,
  output logic [N*DW-1:0]       out_data,
  output logic [N-1:0]          out_blocked
);

  localparam int LOG    = $clog2(N);
  localparam int PW     = pkt_width(LOG, DW);
  localparam int SRC_LO = DW + 2 * LOG;

  logic [N*PW-1:0]      line [LOG+1];
  logic [N/2-1:0]       stage_blk [LOG];
  logic [N/2*LOG-1:0]   stage_blk_src [LOG];
  logic [N-1:0]         blocked_next;
  logic                 any_conflict;
  logic [N-1:0]         valid_next;
  logic [N*LOG-1:0]     src_next;
  logic [N*DW-1:0]      data_next;

  // Entry: build packets, mask only counts when broadcast is requested
  for (genvar j = 0; j < N; j++) begin : g_entry
    assign line[0][j*PW +: PW] = {in_valid[j], LOG'(j), in_dst[j*LOG +: LOG],
                                  {LOG{in_bcast[j]}} & in_mask[j*LOG +: LOG],
                                  in_data[j*DW +: DW]};
  end

  for (genvar s = 0; s < LOG; s++) begin : g_stage
    omega_stage #(.N(N), .LOG(LOG), .DW(DW), .STAGE(s)) u_stage (
      .lines_i   (line[s]),
      .lines_o   (line[s+1]),
      .blk_o     (stage_blk[s]),
      .blk_src_o (stage_blk_src[s])
    );
  end

  // Gather drop events from every switch into per-source flags
  always_comb begin
    blocked_next = '0;
    for (int s = 0; s < LOG; s++) begin
      for (int k = 0; k < N/2; k++) begin
        if (stage_blk[s][k]) blocked_next[stage_blk_src[s][k*LOG +: LOG]] = 1'b1;
      end
    end
  end
  assign any_conflict = |blocked_next;

  always_comb begin
    for (int j = 0; j < N; j++) begin
      valid_next[j]          = line[LOG][j*PW + PW - 1];
      src_next[j*LOG +: LOG] = valid_next[j] ? line[LOG][j*PW + SRC_LO +: LOG] : '0;
      data_next[j*DW +: DW]  = valid_next[j] ? line[LOG][j*PW +: DW] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= '0;
      out_src     <= '0;
      out_data    <= '0;
      out_blocked <= '0;
    end else begin
      out_valid   <= valid_next;
      out_src     <= src_next;
      out_data    <= data_next;
      out_blocked <= blocked_next;
    end
  end

endmodule

// File: rtl/omega_router_chk.sv
module omega_router_chk #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N-1:0]          in_valid,
  input logic [N-1:0]          in_bcast,
  input logic [N*$clog2(N)-1:0] in_dst,
  input logic [N*$clog2(N)-1:0] in_mask,
  input logic [N-1:0]          out_valid,
  input logic [N*$clog2(N)-1:0] out_src,
  input logic [N-1:0]          out_blocked,
  input logic                  any_conflict
);

  localparam int LOG = $clog2(N);

  logic [N-1:0]     p_valid;
  logic [N*LOG-1:0] p_dst, p_mask;
  logic [N-1:0]     dest_ok, count_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid <= '0;
      p_dst   <= '0;
      p_mask  <= '0;
    end else begin
      p_valid <= in_valid;
      p_dst   <= in_dst;
      for (int i = 0; i < N; i++)
        p_mask[i*LOG +: LOG] <= in_bcast[i] ? in_mask[i*LOG +: LOG] : '0;
    end
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      int sj;
      sj = int'(out_src[j*LOG +: LOG]);
      dest_ok[j] = !out_valid[j] ||
                   (p_valid[sj] &&
                    (((p_dst[sj*LOG +: LOG] ^ LOG'(j)) & ~p_mask[sj*LOG +: LOG]) == '0));
    end
    for (int i = 0; i < N; i++) begin
      int cnt, want;
      cnt  = 0;
      want = 1 << $countones(p_mask[i*LOG +: LOG]);
      for (int j = 0; j < N; j++)
        if (out_valid[j] && int'(out_src[j*LOG +: LOG]) == i) cnt++;
      if (!p_valid[i]) count_ok[i] = (cnt == 0) && !out_blocked[i];
      else if (out_blocked[i]) count_ok[i] = (cnt < want);
      else count_ok[i] = (cnt == want);
    end
  end

  // R3 / R7: every delivered copy sits on a port its destination allows
  a_r3_dest_match: assert property (@(posedge clk) disable iff (!rst_n)
    dest_ok == {N{1'b1}});

  // R9: full group for clean sources, short group for blocked ones
  a_r9_copy_count: assert property (@(posedge clk) disable iff (!rst_n)
    count_ok == {N{1'b1}});

  // R10: a lone request always gets through
  a_r10_lone_request: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(p_valid) == 1) |-> (out_blocked == '0));

  // R5: a switch drop shows up as a blocked flag one edge later
  a_r5_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    any_conflict |=> (out_blocked != '0));

  // R6: no request, no output and no blocked flag
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid == '0) |-> (out_valid == '0 && out_blocked == '0));

endmodule

bind omega_router omega_router_chk #(.N(N), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_bcast     (in_bcast),
  .in_dst       (in_dst),
  .in_mask      (in_mask),
  .out_valid    (out_valid),
  .out_src      (out_src),
  .out_blocked  (out_blocked),
  .any_conflict (any_conflict)
);

// File: tb/omega_router_test.sv
`timescale 1ns/1ps
module omega_router_test;
  localparam int N = 8, LOG = 3, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] in_valid, in_bcast, out_valid, out_blocked;
  logic [N*LOG-1:0] in_dst, in_mask, out_src;
  logic [N*DW-1:0] in_data, out_data;

  omega_router #(.N(N), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bcast(in_bcast),
    .in_dst(in_dst), .in_mask(in_mask), .in_data(in_data),
    .out_valid(out_valid), .out_src(out_src), .out_data(out_data),
    .out_blocked(out_blocked));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5679;
  int tv[N], tbc[N], td[N], tm[N], tdat[N];
  int ev[N], esrc[N], eblk[N];

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  function automatic int rot(int x);
    return ((x << 1) | (x >> (LOG - 1))) & (N - 1);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < N; i++) begin
      tv[i] = 0; tbc[i] = 0; td[i] = 0; tm[i] = 0; tdat[i] = int'(rnd() & 255);
    end
  endtask

  // Which output ports source s asks for at a given stage (bit0 upper)
  function automatic int asks(int s, int stg);
    int b, m;
    b = LOG - 1 - stg;
    m = tbc[s] ? ((tm[s] >> b) & 1) : 0;
    if (m != 0) return 3;
    return ((td[s] >> b) & 1) ? 2 : 1;
  endfunction

  // Reference: walk copies stage by stage, upper switch input served first
  task automatic model();
    int occ[N], sh[N];
    for (int i = 0; i < N; i++) begin occ[i] = tv[i] ? i : -1; eblk[i] = 0; end
    for (int stg = 0; stg < LOG; stg++) begin
      for (int p = 0; p < N; p++) sh[rot(p)] = occ[p];
      for (int p = 0; p < N; p++) occ[p] = -1;
      for (int k = 0; k < N/2; k++) begin
        int taken, w;
        taken = 0;
        if (sh[2*k] >= 0) begin
          taken = asks(sh[2*k], stg);
          if (taken & 1) occ[2*k] = sh[2*k];
          if (taken & 2) occ[2*k+1] = sh[2*k];
        end
        if (sh[2*k+1] >= 0) begin
          w = asks(sh[2*k+1], stg);
          if ((w & taken) != 0) eblk[sh[2*k+1]] = 1;
          else begin
            if (w & 1) occ[2*k] = sh[2*k+1];
            if (w & 2) occ[2*k+1] = sh[2*k+1];
          end
        end
      end
    end
    for (int j = 0; j < N; j++) begin ev[j] = occ[j] >= 0; esrc[j] = occ[j]; end
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      in_valid[i] = tv[i][0];
      in_bcast[i] = tbc[i][0];
      in_dst[i*LOG +: LOG]  = LOG'(td[i]);
      in_mask[i*LOG +: LOG] = LOG'(tm[i]);
      in_data[i*DW +: DW]   = DW'(tdat[i]);
    end
  endtask

  task automatic run_case(string req);
    @(negedge clk);
    drive();
    model();
    @(negedge clk);
    for (int j = 0; j < N; j++) begin
      check(req, $sformatf("valid[%0d]", j), int'(out_valid[j]), ev[j]);
      if (ev[j] != 0) begin
        check(req, $sformatf("src[%0d]", j), int'(out_src[j*LOG +: LOG]), esrc[j]);
        check(req, $sformatf("data[%0d]", j), int'(out_data[j*DW +: DW]), tdat[esrc[j]]);
      end
    end
    for (int i = 0; i < N; i++)
      check(req, $sformatf("blocked[%0d]", i), int'(out_blocked[i]), eblk[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    in_valid = '1; in_bcast = '0; in_dst = '0; in_mask = '0; in_data = '1;
    repeat (3) @(negedge clk);
    // R1: reset holds every output at zero even with requests present
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "out_blocked in reset", int'(out_blocked), 0);
    check("R1", "out_data in reset", int'(out_data != '0), 0);
    check("R1", "out_src in reset", int'(out_src != '0), 0);
    clear_stim(); drive();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);

    // R2: result appears only at the next rising edge
    clear_stim(); tv[3] = 1; td[3] = 6;
    drive();
    #2 check("R2", "out_valid before edge", int'(out_valid), 0);
    @(negedge clk);
    check("R2", "out_valid after edge", int'(out_valid), 8'h40);
    check("R2", "out_src after edge", int'(out_src[6*LOG +: LOG]), 3);

    // R6: idle inputs give quiet outputs
    clear_stim();
    for (int i = 0; i < N; i++) begin td[i] = i; tm[i] = 7; end
    run_case("R6");

    // R4: every cyclic shift passes in one go
    for (int c = 0; c < N; c++) begin
      clear_stim();
      for (int i = 0; i < N; i++) begin tv[i] = 1; td[i] = (i + c) % N; end
      run_case("R4");
      check("R4", "no input blocked", int'(out_blocked), 0);
      check("R4", "all ports served", int'(out_valid), 8'hFF);
    end

    // R5: inputs 0 and 4 both to port 0, upper input 0 wins
    clear_stim(); tv[0] = 1; tv[4] = 1;
    run_case("R5");
    check("R5", "winner port mask", int'(out_valid), 8'h01);
    check("R5", "blocked mask", int'(out_blocked), 8'h10);
    check("R5", "winner source", int'(out_src[0 +: LOG]), 0);

    // R10: input 4 alone to port 0 is served
    clear_stim(); tv[4] = 1;
    run_case("R10");
    check("R10", "lone port mask", int'(out_valid), 8'h01);

    // R9: input 2 broadcasts to all, input 0 takes one branch away
    clear_stim(); tv[2] = 1; tbc[2] = 1; tm[2] = 7; tv[0] = 1; td[0] = 0;
    run_case("R9");
    check("R9", "surviving ports", int'(out_valid), 8'hF1);
    check("R9", "blocked mask", int'(out_blocked), 8'h04);
    for (int j = 4; j < 8; j++)
      check("R9", $sformatf("copy source port %0d", j), int'(out_src[j*LOG +: LOG]), 2);

    // R7 / R10: every lone broadcast over every aligned group
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++)
        for (int k = 0; k <= LOG; k++) begin
          int expv;
          clear_stim(); tv[s] = 1; tbc[s] = 1; td[s] = d; tm[s] = (1 << k) - 1;
          run_case("R7");
          expv = 0;
          for (int p = 0; p < N; p++) if ((p >> k) == (d >> k)) expv |= 1 << p;
          check("R7", "group ports", int'(out_valid), expv);
          check("R10", "lone broadcast not blocked", int'(out_blocked), 0);
        end

    // R8: mask without broadcast flag changes nothing
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        clear_stim(); tv[s] = 1; td[s] = d; tm[s] = 7;
        run_case("R8");
        check("R8", "single port", int'(out_valid), 1 << d);
      end

    // R3 / R5 / R6: random permutations with partial load and stray masks
    for (int n = 0; n < 400; n++) begin
      int perm[N];
      clear_stim();
      for (int i = 0; i < N; i++) perm[i] = i;
      for (int i = N - 1; i > 0; i--) begin
        int j, t;
        j = int'(rnd() % (i + 1)); t = perm[i]; perm[i] = perm[j]; perm[j] = t;
      end
      for (int i = 0; i < N; i++) begin
        tv[i] = (rnd() % 4) != 0; td[i] = perm[i]; tm[i] = int'(rnd() & 7);
      end
      run_case("R3");
    end

    // R9: random mixtures of unicast and aligned broadcast
    for (int n = 0; n < 300; n++) begin
      clear_stim();
      for (int i = 0; i < N; i++) begin
        tv[i] = (rnd() % 3) != 0; td[i] = int'(rnd() % N);
        tbc[i] = (rnd() % 4) == 0; tm[i] = (1 << (rnd() % (LOG + 1))) - 1;
      end
      run_case("R9");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule